// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital phase controller for a successive-approximation converter. It counts every phase in ADC clock cycles, which arrive as a one-cycle enable (`adc_tick`) on the system clock. The prescaler that makes that enable is outside the block, and so are the analog core, the bit-decision logic and the result path. The converter itself is modelled as a fixed number of ticks.

When `enable` rises, the sequencer runs a start-up wait. For differential channels it then runs an amplifier settling period. After a fixed setup delay it issues the sample strobe and holds a busy flag for the conversion. At the end of the conversion it pulses a result-write strobe and sets the interrupt flag. A mandatory tracking period always follows a conversion. Starts come from one of three sources, chosen by the mode:
- software, setting the start bit;
- a free-running chain that begins again after each tracking period while the start bit stays set;
- an external trigger, which is re-timed over three extra system clocks.

A start request that arrives while the sequencer is busy is kept, not dropped. Dropping `enable` aborts whatever phase is running.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and `enable` is low, `start_bit`, `sample_strobe`, `conv_busy`, `result_wr` and `irq_flag` are all 0. After `enable` rises, a start-up wait of STARTUP_TICKS ticks (default 4) runs before any sampling. Enabling the block together with a software start on a single-ended channel gives a sample strobe STARTUP_TICKS + SETUP_TICKS ticks (default 6) after enable.
- R2: From the ready state, a software start on a single-ended channel produces `sample_strobe` exactly SETUP_TICKS ticks (default 2) after the request.
- R3: `conv_busy` is high when the sample strobe is seen. `result_wr` follows the sample strobe by exactly CONV_TICKS ticks (default 11).
- R4: `irq_flag` becomes 1 in the same cycle that `result_wr` pulses.
- R5: In single mode (`mode` = 2'b00) and in triggered mode, `start_bit` is 0 in the same cycle that `result_wr` pulses, unless a request is pending.
- R6: On a single-ended channel the tracking period lasts 4×(`track_sel`+1) ticks. In free-running mode (`mode` = 2'b01), successive sample strobes are therefore 11 + 4×(`track_sel`+1) + SETUP_TICKS ticks apart (17 for setting 0, 29 for setting 3).
- R7: On a differential channel (`diff_chan` = 1), tracking lasts 8×(`track_sel`+1) ticks, and an amplifier settling period of 2×(`track_sel`+2) ticks comes before every setup delay. At setting 1 the first sample follows enable by 4+6+2 = 12 ticks, and free-running samples are 11+16+6+2 = 35 ticks apart.
- R8: In free-running mode, conversions keep chaining while `start_bit` stays 1, with no further software requests.
- R9: In triggered mode (`mode` = 2'b10), a rising edge of `auto_trig` sets `start_bit` 4 system cycles after the edge is applied. This is 3 cycles later than a software start, which sets it after 1 cycle. In single mode, `auto_trig` does not set `start_bit`.
- R10: A software start during a conversion is held. `start_bit` stays 1 at completion, and the next sample strobe follows `result_wr` by the tracking length plus SETUP_TICKS ticks (6 for single-ended, setting 0).
- R11: `irq_flag` stays set until an `irq_clr` pulse. When a clear and a completion fall in the same cycle, the flag stays set.
- R12: When `enable` goes low, `conv_busy` and `start_bit` are 0 one cycle later, and no further sample or result strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter enable; low aborts and idles |
| adc_tick | input | 1 | One-cycle pulse per ADC clock cycle |
| mode | input | 2 | 00 single, 01 free-running, 10 triggered |
| diff_chan | input | 1 | 1 = differential channel |
| track_sel | input | 2 | Tracking-time setting |
| sw_start | input | 1 | Software pulse that sets the start bit |
| auto_trig | input | 1 | External trigger, rising edge active |
| irq_clr | input | 1 | Pulse that clears the interrupt flag |
| start_bit | output | 1 | Start bit as seen by software |
| sample_strobe | output | 1 | One-cycle sample-and-hold strobe |
| conv_busy | output | 1 | High during the conversion phase |
| result_wr | output | 1 | One-cycle result-write strobe |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
The assertions assume that `adc_tick` is a single-cycle pulse spaced at least two system cycles apart. They also assume that `mode`, `diff_chan` and `track_sel` change only while `enable` is low. The bench keeps to both rules: it makes one tick every four cycles and changes the configuration only between runs, after a reset. Trigger and software pulses last one or a few cycles and are applied on the falling clock edge just after a tick. This makes the tick counts expected by the bench exact.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_FREE   = 2'b01,
    MODE_AUTO   = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WARM, S_READY, S_AMP, S_SETUP, S_CONV, S_TRACK
  } seq_state_e;

  function automatic int unsigned track_ticks(input logic [1:0] sel, input logic diff);
    int unsigned base;
    base = (32'(sel) + 32'd1) * 32'd4;
    return diff ? base * 32'd2 : base;
  endfunction

  function automatic int unsigned amp_ticks(input logic [1:0] sel);
    return (32'(sel) + 32'd2) * 32'd2;
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic req
);
  logic              trig_d;
  logic [STAGES-1:0] pipe;
  logic              rise;

  assign rise = trig & ~trig_d;
  assign req  = pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d <= 1'b0;
      pipe   <= '0;
    end else begin
      trig_d <= trig;
      pipe   <= {pipe[STAGES-2:0], rise};
    end
  end

  // R9: a synchronized trigger is a single-cycle request
  a_r9_one_shot: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
endmodule

// File: rtl/adc_irq_flag.sv
module adc_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R11: the flag drops only on a clear without a concurrent completion
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> ($past(clr) && !$past(set)));
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int STARTUP_TICKS = 4,
  parameter int SETUP_TICKS   = 2,
  parameter int CONV_TICKS    = 11,
  parameter int CNT_W         = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       adc_tick,
  input  logic [1:0] mode,
  input  logic       diff_chan,
  input  logic [1:0] track_sel,
  input  logic       req,
  output logic       start_bit,
  output logic       sample_strobe,
  output logic       conv_busy,
  output logic       result_wr,
  output logic       done_now
);
  localparam logic [CNT_W-1:0] WARM_LD  = CNT_W'(STARTUP_TICKS - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_TICKS - 1);
  localparam logic [CNT_W-1:0] CONV_LD  = CNT_W'(CONV_TICKS - 1);

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             pend_q;
  logic             tick_end;
  logic             chained;
  logic [CNT_W-1:0] amp_ld, trk_ld;
  seq_state_e       launch_st;
  logic [CNT_W-1:0] launch_ld;

  assign tick_end  = adc_tick && (cnt == '0);
  assign done_now  = !rst && enable && (st == S_CONV) && tick_end;
  assign chained   = (mode == MODE_FREE);
  assign amp_ld    = CNT_W'(amp_ticks(track_sel) - 1);
  assign trk_ld    = CNT_W'(track_ticks(track_sel, diff_chan) - 1);
  assign launch_st = diff_chan ? S_AMP : S_SETUP;
  assign launch_ld = diff_chan ? amp_ld : SETUP_LD;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      st            <= S_IDLE;
      cnt           <= '0;
      pend_q        <= 1'b0;
      start_bit     <= 1'b0;
      sample_strobe <= 1'b0;
      conv_busy     <= 1'b0;
      result_wr     <= 1'b0;
    end else begin
      sample_strobe <= 1'b0;
      result_wr     <= 1'b0;
      if (req) begin
        start_bit <= 1'b1;
        if (st == S_CONV) pend_q <= 1'b1;
      end
      case (st)
        S_IDLE: begin
          st  <= S_WARM;
          cnt <= WARM_LD;
        end
        S_WARM: if (adc_tick) begin
          if (tick_end) st <= S_READY;
          else          cnt <= cnt - 1'b1;
        end
        S_READY: if (start_bit) begin
          st  <= launch_st;
          cnt <= launch_ld;
        end
        S_AMP: if (adc_tick) begin
          if (tick_end) begin
            st  <= S_SETUP;
            cnt <= SETUP_LD;
          end else cnt <= cnt - 1'b1;
        end
        S_SETUP: if (adc_tick) begin
          if (tick_end) begin
            st            <= S_CONV;
            cnt           <= CONV_LD;
            sample_strobe <= 1'b1;
            conv_busy     <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_CONV: if (adc_tick) begin
          if (tick_end) begin
            st        <= S_TRACK;
            cnt       <= trk_ld;
            conv_busy <= 1'b0;
            result_wr <= 1'b1;
            if (!chained) begin
              start_bit <= pend_q | req;
              pend_q    <= 1'b0;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_TRACK: if (adc_tick) begin
          if (tick_end) begin
            st  <= start_bit ? launch_st : S_READY;
            cnt <= launch_ld;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Assertion-only tick counter across the busy window
  logic [CNT_W-1:0] a_busy_ticks;
  always_ff @(posedge clk) begin
    if (rst || !conv_busy) a_busy_ticks <= '0;
    else if (adc_tick)     a_busy_ticks <= a_busy_ticks + 1'b1;
  end

  // R3: a result write closes a busy window of exactly CONV_TICKS ticks
  a_r3_conv_len: assert property (@(posedge clk) disable iff (rst)
    result_wr |-> (a_busy_ticks == CNT_W'(CONV_TICKS)));
  // R3: the strobe opens the busy window
  a_r3_sample_busy: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |-> conv_busy);
  // R5: the start bit falls only at a completion or on disable
  a_r5_start_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(start_bit) |-> (result_wr || !$past(enable)));
  // R12: disable idles the block one cycle later
  a_r12_abort: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (!conv_busy && !start_bit && !result_wr));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int STARTUP_TICKS = 4,
  parameter int SETUP_TICKS   = 2,
  parameter int CONV_TICKS    = 11,
  parameter int SYNC_STAGES   = 3,
  parameter int CNT_W         = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       adc_tick,
  input  logic [1:0] mode,
  input  logic       diff_chan,
  input  logic [1:0] track_sel,
  input  logic       sw_start,
  input  logic       auto_trig,
  input  logic       irq_clr,
  output logic       start_bit,
  output logic       sample_strobe,
  output logic       conv_busy,
  output logic       result_wr,
  output logic       irq_flag
);
  logic trig_req, req, done_now;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig(auto_trig), .req(trig_req)
  );

  assign req = sw_start | (trig_req && (mode == MODE_AUTO));

  adc_seq_core #(
    .STARTUP_TICKS(STARTUP_TICKS), .SETUP_TICKS(SETUP_TICKS),
    .CONV_TICKS(CONV_TICKS), .CNT_W(CNT_W)
  ) u_core (
    .clk(clk), .rst(rst), .enable(enable), .adc_tick(adc_tick),
    .mode(mode), .diff_chan(diff_chan), .track_sel(track_sel), .req(req),
    .start_bit(start_bit), .sample_strobe(sample_strobe),
    .conv_busy(conv_busy), .result_wr(result_wr), .done_now(done_now)
  );

  adc_irq_flag u_irq (
    .clk(clk), .rst(rst), .set(done_now), .clr(irq_clr), .flag(irq_flag)
  );

  // R4: flag and result write appear together
  a_r4_irq_with_wr: assert property (@(posedge clk) disable iff (rst)
    result_wr |-> irq_flag);
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1, enable = 1'b0, adc_tick = 1'b0, diff_chan = 1'b0;
  logic [1:0] mode = 2'b00, track_sel = 2'b00;
  logic sw_start = 1'b0, auto_trig = 1'b0, irq_clr = 1'b0;
  logic start_bit, sample_strobe, conv_busy, result_wr, irq_flag;

  always #2 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst(rst), .enable(enable), .adc_tick(adc_tick), .mode(mode),
    .diff_chan(diff_chan), .track_sel(track_sel), .sw_start(sw_start),
    .auto_trig(auto_trig), .irq_clr(irq_clr), .start_bit(start_bit),
    .sample_strobe(sample_strobe), .conv_busy(conv_busy),
    .result_wr(result_wr), .irq_flag(irq_flag)
  );

  int div = 0;
  always @(negedge clk) begin
    div = (div + 1) % 4;
    adc_tick = (div == 0);
  end

  int tc = 0, n_sample = 0, n_done = 0, samp_tc = 0, done_tc = 0;
  logic busy_at_samp = 1'b0, irq_at_wr = 1'b0, start_at_wr = 1'b0;
  always @(posedge clk) begin
    if (adc_tick) tc <= tc + 1;
    if (sample_strobe) begin
      n_sample <= n_sample + 1; samp_tc <= tc; busy_at_samp <= conv_busy;
    end
    if (result_wr) begin
      n_done <= n_done + 1; done_tc <= tc;
      irq_at_wr <= irq_flag; start_at_wr <= start_bit;
    end
  end

  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    enable = 0; rst = 1; sw_start = 0; auto_trig = 0; irq_clr = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic align_tick();
    @(posedge clk iff adc_tick);
    @(negedge clk);
  endtask

  task automatic begin_run(input logic [1:0] m, input logic d, input logic [1:0] t,
                           input logic with_start, output int t0);
    reset_dut();
    mode = m; diff_chan = d; track_sel = t;
    align_tick();
    enable = 1; sw_start = with_start; t0 = tc;
    @(negedge clk);
    sw_start = 0;
  endtask

  task automatic wait_sample(input int target);
    for (int g = 0; g < 5000 && n_sample < target; g++) @(negedge clk);
  endtask

  task automatic wait_done(input int target);
    for (int g = 0; g < 5000 && n_done < target; g++) @(negedge clk);
  endtask

  task automatic pulse_start(output int t0);
    align_tick();
    sw_start = 1; t0 = tc;
    @(negedge clk);
    sw_start = 0;
  endtask

  task automatic test_reset();
    reset_dut();
    check("R1 start_bit after reset", int'(start_bit), 0);
    check("R1 sample_strobe after reset", int'(sample_strobe), 0);
    check("R1 conv_busy after reset", int'(conv_busy), 0);
    check("R1 result_wr after reset", int'(result_wr), 0);
    check("R1 irq_flag after reset", int'(irq_flag), 0);
  endtask

  task automatic test_startup();
    int t0;
    begin_run(2'b00, 1'b0, 2'd0, 1'b1, t0);
    wait_sample(n_sample + 1);
    check("R1 enable to first sample ticks", samp_tc - t0, 6);
    begin_run(2'b00, 1'b1, 2'd1, 1'b1, t0);
    wait_sample(n_sample + 1);
    check("R7 differential enable to first sample ticks", samp_tc - t0, 12);
  endtask

  task automatic test_single();
    int t0;
    begin_run(2'b00, 1'b0, 2'd0, 1'b1, t0);
    wait_done(n_done + 1);
    repeat (40) @(negedge clk);
    pulse_start(t0);
    wait_sample(n_sample + 1);
    check("R2 start to sample ticks", samp_tc - t0, 2);
    check("R3 busy at sample", int'(busy_at_samp), 1);
    wait_done(n_done + 1);
    check("R3 sample to result ticks", done_tc - samp_tc, 11);
    check("R4 irq with result write", int'(irq_at_wr), 1);
    check("R5 start bit at completion", int'(start_at_wr), 0);
    check("R5 start bit after completion", int'(start_bit), 0);
  endtask

  task automatic test_free();
    int t0, s1;
    begin_run(2'b01, 1'b0, 2'd0, 1'b1, t0);
    wait_sample(n_sample + 1); s1 = samp_tc;
    wait_sample(n_sample + 1);
    check("R6 free-run spacing setting 0", samp_tc - s1, 17);
    s1 = samp_tc;
    wait_sample(n_sample + 1);
    check("R8 free-run keeps chaining", samp_tc - s1, 17);
    begin_run(2'b01, 1'b0, 2'd3, 1'b1, t0);
    wait_sample(n_sample + 1); s1 = samp_tc;
    wait_sample(n_sample + 1);
    check("R6 free-run spacing setting 3", samp_tc - s1, 29);
    begin_run(2'b01, 1'b1, 2'd1, 1'b1, t0);
    wait_sample(n_sample + 1); s1 = samp_tc;
    wait_sample(n_sample + 1);
    check("R7 differential free-run spacing", samp_tc - s1, 35);
  endtask

  task automatic test_pending();
    int t0;
    begin_run(2'b00, 1'b0, 2'd0, 1'b1, t0);
    wait_sample(n_sample + 1);
    repeat (3) @(negedge clk);
    sw_start = 1; @(negedge clk); sw_start = 0;
    wait_done(n_done + 1);
    check("R10 start held at completion", int'(start_at_wr), 1);
    wait_sample(n_sample + 1);
    check("R10 result to next sample ticks", samp_tc - done_tc, 6);
  endtask

  task automatic test_auto();
    int t0, c, ns;
    begin_run(2'b10, 1'b0, 2'd0, 1'b0, t0);
    repeat (40) @(negedge clk);
    ns = n_sample;
    auto_trig = 1; c = 0;
    while (!start_bit && c < 20) begin @(negedge clk); c++; end
    auto_trig = 0;
    check("R9 trigger to start bit cycles", c, 4);
    wait_sample(ns + 1);
    check("R9 triggered sample occurs", n_sample - ns, 1);
    begin_run(2'b10, 1'b0, 2'd0, 1'b0, t0);
    repeat (40) @(negedge clk);
    sw_start = 1; c = 0;
    while (!start_bit && c < 20) begin @(negedge clk); c++; sw_start = 0; end
    sw_start = 0;
    check("R9 software start to start bit cycles", c, 1);
    begin_run(2'b00, 1'b0, 2'd0, 1'b0, t0);
    repeat (40) @(negedge clk);
    ns = n_sample;
    auto_trig = 1; repeat (2) @(negedge clk); auto_trig = 0;
    repeat (60) @(negedge clk);
    check("R9 trigger ignored in single mode", int'(start_bit), 0);
    check("R9 no sample in single mode from trigger", n_sample - ns, 0);
  endtask

  task automatic test_irq();
    int t0;
    begin_run(2'b00, 1'b0, 2'd0, 1'b1, t0);
    wait_done(n_done + 1);
    repeat (20) @(negedge clk);
    check("R11 irq held without clear", int'(irq_flag), 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
    check("R11 irq cleared by pulse", int'(irq_flag), 0);
    irq_clr = 1;
    pulse_start(t0);
    wait_done(n_done + 1);
    check("R11 completion wins over clear", int'(irq_at_wr), 1);
    repeat (2) @(negedge clk);
    check("R11 clear applies after completion", int'(irq_flag), 0);
    irq_clr = 0;
  endtask

  task automatic test_disable();
    int t0, nd, ns;
    begin_run(2'b01, 1'b0, 2'd0, 1'b1, t0);
    wait_sample(n_sample + 1);
    @(negedge clk);
    enable = 0;
    @(negedge clk);
    check("R12 busy cleared on disable", int'(conv_busy), 0);
    check("R12 start bit cleared on disable", int'(start_bit), 0);
    nd = n_done; ns = n_sample;
    repeat (200) @(negedge clk);
    check("R12 no result after disable", n_done - nd, 0);
    check("R12 no sample after disable", n_sample - ns, 0);
  endtask

  initial begin
    test_reset();
    test_startup();
    test_single();
    test_free();
    test_pending();
    test_auto();
    test_irq();
    test_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule